// File: doc/BRIEF.md
# Floppy Controller Reset Arbiter

This block merges every source that can reset a floppy disk controller core into one core-reset level and a small set of single-cycle strobes for the rest of the controller. There are four sources. Power-on reset and the external hardware reset pin are asynchronous inputs. Each passes through a two-flop synchroniser. The other two are software bits that the host writes through a one-bit register write port.

The first software bit is a held, active-low reset bit. It stays in reset until the host writes it back to 1. Both hardware sources force it to 0, so the core stays in reset after the pin is released until the host clears the bit. The second software bit is a self-clearing reset. It releases by itself after a fixed number of cycles. The held bit wins over the self-clearing bit: while the held bit is in reset, the self-clearing bit is cleared, and writes that would set it are dropped.

The block drives six outputs besides the readback:
- a power-down exit pulse when a reset begins;
- a configure-class clear pulse each time the core leaves reset;
- a specify-class clear pulse on power-on only;
- a FIFO and drive-status flush pulse when a software reset begins;
- an idle indication;
- the core-reset level itself.

Top module: `fdc_rst_arbiter`

## Requirements
- R1: After `por_i` is raised, `core_rst_o` is 1 on the third rising edge and `rd_data_o` reads 2'b00. `clr_spec_o` gives exactly one single-cycle pulse per power-on assertion, however long `por_i` is held.
- R2: Raising `rst_pin_i` makes `core_rst_o` and `pd_exit_o` go to 1 on the third rising edge, not earlier. The pin forces the held reset bit (`rd_data_o[0]`) to 0, so `core_rst_o` stays 1 after the pin is released. A pin reset never produces `clr_spec_o`.
- R3: The held reset bit is written with `wr_sel_i`=0 and read on `rd_data_o[0]`, where 0 means reset. `core_rst_o` follows a write one rising edge after the edge that takes the write.
- R4: A write with `wr_sel_i`=1 and `wr_bit_i`=1 sets `rd_data_o[1]` on the next edge. It then holds `core_rst_o` at 1 for exactly `DSR_CYCLES` consecutive cycles, after which the bit clears itself.
- R5: While `rd_data_o[0]` is 0, the self-clearing bit is forced to 0 and writes to it are ignored. After the held bit is released, no self-clearing reset tail follows.
- R6: `pd_exit_o` is a single-cycle pulse in the first cycle of `core_rst_o`. It does not pulse again while the core is already in reset.
- R7: `clr_cfg_o` is a single-cycle pulse in the first cycle after `core_rst_o` falls. This holds for every reset source.
- R8: `flush_o` is a single-cycle pulse when a software reset (either bit) becomes active, in the same cycle as the `core_rst_o` rise it causes.
- R9: `idle_o` is always the inverse of `core_rst_o`.
- R10: A write with `wr_sel_i`=1 and `wr_bit_i`=0 has no effect: `rd_data_o` and every output stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| rst_pin_i | input | 1 | External hardware reset, active high, asynchronous |
| wr_en_i | input | 1 | Host write strobe for one reset bit |
| wr_sel_i | input | 1 | Target bit: 0 = held reset bit, 1 = self-clearing reset bit |
| wr_bit_i | input | 1 | Value written |
| rd_data_o | output | 2 | Readback: bit 0 = held reset bit (0 = reset), bit 1 = self-clearing bit |
| core_rst_o | output | 1 | Core reset level |
| clr_cfg_o | output | 1 | Configure-class register clear pulse |
| clr_spec_o | output | 1 | Specify-class register clear pulse (power-on only) |
| flush_o | output | 1 | FIFO and drive-status flush pulse |
| pd_exit_o | output | 1 | Power-down exit pulse |
| idle_o | output | 1 | Core idle, waiting for a command |

## Verification
Each result has a fixed latency:
- Hardware sources cross two synchroniser flops and one output register, so their effect appears at the third rising edge.
- A host write lands in its bit on the edge that takes it and reaches the outputs one edge later.
- A self-clearing reset ends `DSR_CYCLES` edges after it starts.

The bench drives inputs on falling edges and samples on falling edges. It checks exact cycles at those points: pin-reset latency is sampled after each of the first three edges. Where a result is a count, it counts over a window long enough to hold the whole effect: cycles of reset, pulses of a strobe, or specify clears during a long pin reset.

// File: rtl/fdc_rst_pkg.sv
package fdc_rst_pkg;

  // Host write targets
  localparam logic SEL_HELD = 1'b0;
  localparam logic SEL_AUTO = 1'b1;

  // Registered output bundle of the arbiter
  typedef struct packed {
    logic core_rst;
    logic clr_cfg;
    logic clr_spec;
    logic flush;
    logic pd_exit;
    logic idle;
  } rst_out_t;

endpackage

// File: rtl/fdc_rst_sync.sv
module fdc_rst_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/fdc_rst_regs.sv
module fdc_rst_regs
  import fdc_rst_pkg::*;
#(
  parameter int DSR_CYCLES = 16
) (
  input  logic clk,
  input  logic hw_rst_i,
  input  logic wr_en_i,
  input  logic wr_sel_i,
  input  logic wr_bit_i,
  output logic held_n_o,
  output logic auto_o
);

  localparam int CW = (DSR_CYCLES > 1) ? $clog2(DSR_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DSR_CYCLES - 1);

  logic          held_n;
  logic          auto_q;
  logic [CW-1:0] cnt;

  // Held bit: hardware reset forces it into reset, only the host releases it
  always_ff @(posedge clk) begin
    if (hw_rst_i) begin
      held_n <= 1'b0;
    end else if (wr_en_i && wr_sel_i == SEL_HELD) begin
      held_n <= wr_bit_i;
    end
  end

  // Self-clearing bit with its down counter; the held bit has precedence
  always_ff @(posedge clk) begin
    if (hw_rst_i || !held_n) begin
      auto_q <= 1'b0;
      cnt    <= '0;
    end else if (wr_en_i && wr_sel_i == SEL_AUTO && wr_bit_i) begin
      auto_q <= 1'b1;
      cnt    <= LOAD;
    end else if (auto_q) begin
      if (cnt == '0) begin
        auto_q <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign held_n_o = held_n;
  assign auto_o   = auto_q;

endmodule

// File: rtl/fdc_rst_strobes.sv
module fdc_rst_strobes
  import fdc_rst_pkg::*;
(
  input  logic     clk,
  input  logic     por_s_i,
  input  logic     hw_rst_i,
  input  logic     held_n_i,
  input  logic     auto_i,
  output rst_out_t out_o
);

  logic act;
  logic sw_act;
  logic sw_q;
  logic por_q;
  rst_out_t o_q;

  assign sw_act = !held_n_i || auto_i;
  assign act    = hw_rst_i || sw_act;

  always_ff @(posedge clk) begin
    sw_q         <= sw_act;
    por_q        <= por_s_i;
    o_q.core_rst <= act;
    o_q.idle     <= !act;
    o_q.pd_exit  <= act && !o_q.core_rst;
    o_q.clr_cfg  <= !act && o_q.core_rst;
    o_q.flush    <= sw_act && !sw_q;
    o_q.clr_spec <= por_s_i && !por_q;
  end

  assign out_o = o_q;

endmodule

// File: rtl/fdc_rst_arbiter.sv
module fdc_rst_arbiter
  import fdc_rst_pkg::*;
#(
  parameter int DSR_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       rst_pin_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic       wr_bit_i,
  output logic [1:0] rd_data_o,
  output logic       core_rst_o,
  output logic       clr_cfg_o,
  output logic       clr_spec_o,
  output logic       flush_o,
  output logic       pd_exit_o,
  output logic       idle_o
);

  localparam int NSRC = 2;

  logic [NSRC-1:0] raw_src;
  logic [NSRC-1:0] sync_src;
  logic            hw_rst;
  logic            held_n;
  logic            auto_b;
  rst_out_t        outs;

  assign raw_src = {rst_pin_i, por_i};

  fdc_rst_sync #(
    .WIDTH (NSRC),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .d_i(raw_src),
    .q_o(sync_src)
  );

  assign hw_rst = |sync_src;

  fdc_rst_regs #(
    .DSR_CYCLES(DSR_CYCLES)
  ) u_regs (
    .clk     (clk),
    .hw_rst_i(hw_rst),
    .wr_en_i (wr_en_i),
    .wr_sel_i(wr_sel_i),
    .wr_bit_i(wr_bit_i),
    .held_n_o(held_n),
    .auto_o  (auto_b)
  );

  fdc_rst_strobes u_strb (
    .clk     (clk),
    .por_s_i (sync_src[0]),
    .hw_rst_i(hw_rst),
    .held_n_i(held_n),
    .auto_i  (auto_b),
    .out_o   (outs)
  );

  assign rd_data_o  = {auto_b, held_n};
  assign core_rst_o = outs.core_rst;
  assign clr_cfg_o  = outs.clr_cfg;
  assign clr_spec_o = outs.clr_spec;
  assign flush_o    = outs.flush;
  assign pd_exit_o  = outs.pd_exit;
  assign idle_o     = outs.idle;

endmodule

// File: rtl/fdc_rst_arbiter_chk.sv
module fdc_rst_arbiter_chk (
  input logic       clk,
  input logic       por_i,
  input logic [1:0] rd_data_o,
  input logic       core_rst_o,
  input logic       clr_cfg_o,
  input logic       clr_spec_o,
  input logic       flush_o,
  input logic       pd_exit_o,
  input logic       idle_o
);

  // R1
  spec_once_chk: assert property (@(posedge clk) disable iff (por_i)
    clr_spec_o |=> !clr_spec_o);

  // R3
  held_rst_chk: assert property (@(posedge clk) disable iff (por_i)
    !rd_data_o[0] |=> core_rst_o);

  // R5
  held_over_auto_chk: assert property (@(posedge clk) disable iff (por_i)
    !rd_data_o[0] |=> !rd_data_o[1]);

  // R6
  pd_once_chk: assert property (@(posedge clk) disable iff (por_i)
    pd_exit_o |=> !pd_exit_o);

  // R6
  pd_in_rst_chk: assert property (@(posedge clk) disable iff (por_i)
    pd_exit_o |-> core_rst_o);

  // R7
  cfg_once_chk: assert property (@(posedge clk) disable iff (por_i)
    clr_cfg_o |=> !clr_cfg_o);

  // R7
  cfg_after_chk: assert property (@(posedge clk) disable iff (por_i)
    clr_cfg_o |-> !core_rst_o && $past(core_rst_o));

  // R8
  flush_once_chk: assert property (@(posedge clk) disable iff (por_i)
    flush_o |=> !flush_o);

  // R9
  idle_inv_chk: assert property (@(posedge clk) disable iff (por_i)
    idle_o != core_rst_o);

endmodule

bind fdc_rst_arbiter fdc_rst_arbiter_chk u_chk (
  .clk       (clk),
  .por_i     (por_i),
  .rd_data_o (rd_data_o),
  .core_rst_o(core_rst_o),
  .clr_cfg_o (clr_cfg_o),
  .clr_spec_o(clr_spec_o),
  .flush_o   (flush_o),
  .pd_exit_o (pd_exit_o),
  .idle_o    (idle_o)
);

// File: tb/fdc_rst_arbiter_tb.sv
`timescale 1ns/1ps
module fdc_rst_arbiter_tb_top;

  localparam int N = 5;

  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       rst_pin_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic       wr_bit_i = 1'b0;
  logic [1:0] rd_data_o;
  logic       core_rst_o, clr_cfg_o, clr_spec_o, flush_o, pd_exit_o, idle_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fdc_rst_arbiter #(.DSR_CYCLES(N)) dut_i (
    .clk(clk), .por_i(por_i), .rst_pin_i(rst_pin_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_bit_i(wr_bit_i),
    .rd_data_o(rd_data_o), .core_rst_o(core_rst_o), .clr_cfg_o(clr_cfg_o),
    .clr_spec_o(clr_spec_o), .flush_o(flush_o), .pd_exit_o(pd_exit_o),
    .idle_o(idle_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  // Write one bit; returns at the falling edge after the capturing edge
  task automatic wr(input logic sel, input logic b);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_bit_i = b;
    cyc();
    wr_en_i = 1'b0;
  endtask

  // Counts over a window of falling-edge samples
  int c_rst, c_pd, c_cfg, c_fl, c_spec, c_idle_bad;
  task automatic window(input int len);
    c_rst = 0; c_pd = 0; c_cfg = 0; c_fl = 0; c_spec = 0; c_idle_bad = 0;
    for (int i = 0; i < len; i++) begin
      cyc();
      c_rst += int'(core_rst_o); c_pd += int'(pd_exit_o);
      c_cfg += int'(clr_cfg_o); c_fl += int'(flush_o);
      c_spec += int'(clr_spec_o);
      if (idle_o == core_rst_o) c_idle_bad++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 power-on
    cyc();
    window(10);
    chk("R1 clr_spec pulses during por", c_spec, 1);
    chk("R1 core_rst after por", int'(core_rst_o), 1);
    chk("R1 readback after por", int'(rd_data_o), 0);
    chk("R9 idle during por", c_idle_bad, 0);
    por_i = 1'b0;
    window(6);
    chk("R2 still in reset after por release", int'(core_rst_o), 1);
    chk("R1 no extra clr_spec", c_spec, 0);

    // R3 release held bit
    wr(1'b0, 1'b1);
    chk("R3 core_rst one edge after write", int'(core_rst_o), 1);
    chk("R3 readback bit0", int'(rd_data_o[0]), 1);
    cyc();
    chk("R3 core_rst released", int'(core_rst_o), 0);
    chk("R7 clr_cfg on release", int'(clr_cfg_o), 1);
    chk("R9 idle on release", int'(idle_o), 1);
    cyc();
    chk("R7 clr_cfg single cycle", int'(clr_cfg_o), 0);

    // R2 pin reset latency
    rst_pin_i = 1'b1;
    cyc(); chk("R2 no reset after edge 1", int'(core_rst_o), 0);
    cyc(); chk("R2 no reset after edge 2", int'(core_rst_o), 0);
    cyc(); chk("R2 reset after edge 3", int'(core_rst_o), 1);
    chk("R6 pd_exit with pin reset", int'(pd_exit_o), 1);
    window(8);
    chk("R2 no clr_spec on pin reset", c_spec, 0);
    chk("R6 no second pd_exit", c_pd, 0);
    rst_pin_i = 1'b0;
    window(8);
    chk("R2 held bit forced", int'(rd_data_o[0]), 0);
    chk("R2 reset held after pin release", c_rst, 8);
    chk("R2 no clr_spec after pin", c_spec, 0);
    wr(1'b0, 1'b1);
    window(3);
    chk("R7 clr_cfg after pin reset exit", c_cfg, 1);

    // R4 self-clearing sweep with different gaps
    for (int g = 0; g < 4; g++) begin
      window(g + 1);
      wr(1'b1, 1'b1);
      chk("R4 readback bit1 set", int'(rd_data_o[1]), 1);
      window(N + 8);
      chk("R4 reset length", c_rst, N);
      chk("R6 pd_exit count", c_pd, 1);
      chk("R8 flush count", c_fl, 1);
      chk("R7 clr_cfg count", c_cfg, 1);
      chk("R9 idle inverse", c_idle_bad, 0);
      chk("R4 bit1 cleared", int'(rd_data_o[1]), 0);
    end

    // R10 write of 0 to self-clearing bit
    wr(1'b1, 1'b0);
    chk("R10 readback unchanged", int'(rd_data_o), 1);
    window(10);
    chk("R10 no reset", c_rst, 0);
    chk("R10 no strobes", c_pd + c_fl + c_cfg, 0);

    // R8 flush on held-bit reset
    wr(1'b0, 1'b0);
    cyc();
    chk("R8 flush on held reset", int'(flush_o), 1);
    chk("R3 core_rst on held write", int'(core_rst_o), 1);

    // R5 self-clearing write ignored while held
    wr(1'b1, 1'b1);
    chk("R5 bit1 stays 0", int'(rd_data_o[1]), 0);
    window(3);
    wr(1'b0, 1'b1);
    cyc();
    chk("R5 release drops reset", int'(core_rst_o), 0);
    window(N + 6);
    chk("R5 no self-clearing tail", c_rst, 0);

    // R5/R6 held reset arriving during a self-clearing reset
    wr(1'b1, 1'b1);
    window(2);
    wr(1'b0, 1'b0);
    window(N + 6);
    chk("R5 bit1 cleared by held", int'(rd_data_o[1]), 0);
    chk("R6 single pd_exit across both", c_pd, 0);
    chk("R3 reset held", int'(core_rst_o), 1);
    wr(1'b0, 1'b1);
    window(3);
    chk("R7 clr_cfg after combined", c_cfg, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule